// File: doc/BRIEF.md
# Frame-Offset Channel Pattern Generator

This block turns a free-running frame counter into a set of timed control lines. Each output channel is a set/clear element. It turns on when the counter reaches that channel's on offset and turns off when the counter reaches its off offset. The result is one programmable window per frame on every channel. An off offset below the on offset gives a window that runs across the frame boundary.

Software-facing words arrive as plain inputs. These are a per-channel enable word, a per-channel polarity word that inverts the sense of a line, and a packed bus of on and off offsets. A separate `run` input marks when the frame engine is active. Frame counting, synchronisation and register access belong to neighbouring blocks.

The number of channels (up to 32) and the offset width are build parameters. A build-time vector fixes the level each line takes while the block is in reset.

Top module: `chan_pattern_gen`

## Requirements
- R1: When `run` is high, channel i is enabled and `frame_cnt` equals its on offset (and not its off offset), `ch_out[i]` becomes the active level (the inverse of `ch_pol[i]`) one clock later.
- R2: When `run` is high, channel i is enabled and `frame_cnt` equals its off offset, `ch_out[i]` becomes the inactive level (`ch_pol[i]`) one clock later.
- R3: When a channel's on and off offsets are equal, the off match wins and the channel stays inactive on that count.
- R4: An off offset smaller than the on offset produces a window that starts at the on offset, continues through the frame wrap and ends at the off offset in the next frame.
- R5: On counts that match neither offset, an enabled, running channel holds its active/inactive state.
- R6: Bit i of `ch_en` gates channel i. A disabled channel drives `ch_pol[i]` one clock later and its state is cleared, so enabling it later leaves it inactive until its next on match.
- R7: While `run` is low every channel drives its inactive level one clock later and its state is cleared. After `run` returns, a channel stays inactive until its next on match.
- R8: `ch_out[i]` is the registered XOR of the channel's active state with `ch_pol[i]`. Bit 1 selects an active-low line. A polarity change shows one clock later without changing the held state.
- R9: While `rst` is high, `ch_out` takes the low `NUM_CH` bits of `IDLE_POL` at the next clock edge, and every channel state becomes inactive.
- R10: Channel i uses bit i of `ch_en`, bit i of `ch_pol`, `on_ofs[i*OFS_W +: OFS_W]` and `off_ofs[i*OFS_W +: OFS_W]`. Only `NUM_CH` (at most 32) channels exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Frame engine running |
| frame_cnt | input | OFS_W | Current position within the frame |
| ch_en | input | NUM_CH | Per-channel enable, bit i for channel i |
| ch_pol | input | NUM_CH | Per-channel polarity, 1 = active-low |
| on_ofs | input | NUM_CH*OFS_W | Packed on offsets, channel i at i*OFS_W |
| off_ofs | input | NUM_CH*OFS_W | Packed off offsets, channel i at i*OFS_W |
| ch_out | output | NUM_CH | Registered channel levels |

## Verification
Every result of this block is due exactly one clock after the counter value, enable, polarity or `run` level that causes it. The state update and the output register are written in the same edge. The bench changes inputs on the falling edge and samples `ch_out` on the next falling edge, after a single rising edge. Each check therefore pairs one counter value with the level it must produce. Cases that depend on held state, such as wrap windows, re-enable and restart after `run` drops, are checked over consecutive counts so that a missing hold or a missing clear shows on a specific count.

// File: rtl/chan_pattern_pkg.sv
package chan_pattern_pkg;

    localparam int MAX_CHANNELS = 32;

    typedef enum logic {
        LVL_INACTIVE = 1'b0,
        LVL_ACTIVE   = 1'b1
    } act_state_e;

    typedef struct packed {
        logic set_hit;
        logic clr_hit;
    } edge_hits_t;

    typedef struct packed {
        logic running;
        logic enabled;
        logic invert;
    } ch_ctrl_t;

    // Clear has priority over set; idle or disabled forces inactive.
    function automatic act_state_e step_state(ch_ctrl_t c, edge_hits_t h, act_state_e cur);
        if (!c.running || !c.enabled) return LVL_INACTIVE;
        if (h.clr_hit)                return LVL_INACTIVE;
        if (h.set_hit)                return LVL_ACTIVE;
        return cur;
    endfunction

    function automatic logic drive_level(act_state_e s, logic invert);
        return (s == LVL_ACTIVE) ^ invert;
    endfunction

endpackage

// File: rtl/chan_offset_cmp.sv
module chan_offset_cmp #(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0]               cnt,
    input  logic [OFS_W-1:0]               on_at,
    input  logic [OFS_W-1:0]               off_at,
    output chan_pattern_pkg::edge_hits_t   hits
);
    always_comb begin
        hits.set_hit = (cnt == on_at);
        hits.clr_hit = (cnt == off_at);
    end
endmodule

// File: rtl/chan_pattern_cell.sv
module chan_pattern_cell
    import chan_pattern_pkg::*;
#(
    parameter int   OFS_W    = 16,
    parameter logic IDLE_LVL = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OFS_W-1:0] cnt,
    input  logic [OFS_W-1:0] on_at,
    input  logic [OFS_W-1:0] off_at,
    input  ch_ctrl_t         ctrl,
    output logic             lvl
);
    edge_hits_t hits;
    act_state_e st_q, st_d;

    chan_offset_cmp #(.OFS_W(OFS_W)) u_cmp (
        .cnt    (cnt),
        .on_at  (on_at),
        .off_at (off_at),
        .hits   (hits)
    );

    always_comb st_d = step_state(ctrl, hits, st_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= LVL_INACTIVE;
            lvl  <= IDLE_LVL;
        end else begin
            st_q <= st_d;
            lvl  <= drive_level(st_d, ctrl.invert);
        end
    end

    a_r1_set_on_match: assert property (@(posedge clk) disable iff (rst)
        (ctrl.running && ctrl.enabled && (cnt == on_at) && (cnt != off_at))
        |=> (lvl == !$past(ctrl.invert)));

    a_r2_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (ctrl.running && ctrl.enabled && (cnt == off_at))
        |=> (lvl == $past(ctrl.invert)));

    a_r6_r7_idle_level: assert property (@(posedge clk) disable iff (rst)
        !(ctrl.running && ctrl.enabled)
        |=> (lvl == $past(ctrl.invert) && st_q == LVL_INACTIVE));

    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        (ctrl.running && ctrl.enabled && (cnt != on_at) && (cnt != off_at))
        |=> (st_q == $past(st_q)));

    a_r8_polarity_xor: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (lvl == ((st_q == LVL_ACTIVE) ^ $past(ctrl.invert))));
endmodule

// File: rtl/chan_pattern_gen.sv
module chan_pattern_gen
    import chan_pattern_pkg::*;
#(
    parameter int          NUM_CH   = 8,
    parameter int          OFS_W    = 16,
    parameter logic [31:0] IDLE_POL = 32'h0000_00A5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic [OFS_W-1:0]        frame_cnt,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH-1:0]       ch_pol,
    input  logic [NUM_CH*OFS_W-1:0] on_ofs,
    input  logic [NUM_CH*OFS_W-1:0] off_ofs,
    output logic [NUM_CH-1:0]       ch_out
);
    localparam logic [NUM_CH-1:0] IDLE_VEC = IDLE_POL[NUM_CH-1:0];

    initial begin
        a_r10_channel_limit: assert (NUM_CH >= 1 && NUM_CH <= MAX_CHANNELS);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_ctrl_t ctrl;
        always_comb begin
            ctrl.running = run;
            ctrl.enabled = ch_en[i];
            ctrl.invert  = ch_pol[i];
        end

        chan_pattern_cell #(
            .OFS_W    (OFS_W),
            .IDLE_LVL (IDLE_VEC[i])
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .cnt    (frame_cnt),
            .on_at  (on_ofs[i*OFS_W +: OFS_W]),
            .off_at (off_ofs[i*OFS_W +: OFS_W]),
            .ctrl   (ctrl),
            .lvl    (ch_out[i])
        );
    end

    a_r9_reset_levels: assert property (@(posedge clk)
        rst |=> (ch_out == IDLE_VEC));
endmodule

// File: tb/chan_pattern_gen_test.sv
`timescale 1ns/1ps
module chan_pattern_gen_test;
    localparam int NUM_CH = 8;
    localparam int OFS_W  = 16;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    run;
    logic [OFS_W-1:0]        frame_cnt;
    logic [NUM_CH-1:0]       ch_en;
    logic [NUM_CH-1:0]       ch_pol;
    logic [NUM_CH*OFS_W-1:0] on_ofs;
    logic [NUM_CH*OFS_W-1:0] off_ofs;
    logic [NUM_CH-1:0]       ch_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    chan_pattern_gen #(.NUM_CH(NUM_CH), .OFS_W(OFS_W), .IDLE_POL(32'h0000_00A5)) uut (
        .clk(clk), .rst(rst), .run(run), .frame_cnt(frame_cnt),
        .ch_en(ch_en), .ch_pol(ch_pol), .on_ofs(on_ofs), .off_ofs(off_ofs),
        .ch_out(ch_out)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick(input int c);
        frame_cnt = c[OFS_W-1:0];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ofs(input int ch, input int on_v, input int off_v);
        on_ofs[ch*OFS_W +: OFS_W]  = on_v[OFS_W-1:0];
        off_ofs[ch*OFS_W +: OFS_W] = off_v[OFS_W-1:0];
    endtask

    task automatic clear_all();
        run = 1'b0;
        tick(15);
        run = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(32'(ch_out), 32'h0000_00A5, "R9 reset levels");
        @(posedge clk); @(negedge clk);
        chk(32'(ch_out), 32'h0000_00A5, "R9 reset held");
        rst = 1'b0;
        tick(0);
        chk(32'(ch_out), 32'h0, "R7 idle after reset");
    endtask

    task automatic t_basic();
        ch_en = 8'h01; ch_pol = 8'h00; set_ofs(0, 3, 7);
        clear_all();
        for (int c = 0; c < 10; c++) begin
            tick(c);
            chk(32'(ch_out[0]), 32'((c >= 3) && (c < 7)), "R1 R2 R5 basic window");
        end
    endtask

    task automatic t_equal();
        ch_en = 8'h02; ch_pol = 8'h00; set_ofs(1, 5, 5);
        clear_all();
        for (int c = 0; c < 10; c++) begin
            tick(c);
            chk(32'(ch_out[1]), 32'h0, "R3 equal offsets");
        end
    endtask

    task automatic t_wrap();
        ch_en = 8'h04; ch_pol = 8'h00; set_ofs(2, 8, 2);
        clear_all();
        for (int f = 0; f < 2; f++) begin
            for (int c = 0; c < 10; c++) begin
                tick(c);
                chk(32'(ch_out[2]), 32'((c >= 8) || (f == 1 && c < 2)), "R4 wrapped window");
            end
        end
    endtask

    task automatic t_polarity();
        ch_en = 8'h08; ch_pol = 8'h08; set_ofs(3, 2, 4);
        clear_all();
        for (int c = 0; c < 6; c++) begin
            tick(c);
            chk(32'(ch_out[3]), 32'(!((c >= 2) && (c < 4))), "R8 active-low window");
        end
        tick(0); tick(1); tick(2);
        chk(32'(ch_out[3]), 32'h0, "R8 active-low on");
        ch_pol = 8'h00;
        tick(3);
        chk(32'(ch_out[3]), 32'h1, "R8 polarity flip keeps state");
    endtask

    task automatic t_enable();
        ch_en = 8'h01; ch_pol = 8'h10; set_ofs(4, 1, 6); set_ofs(0, 1, 6);
        clear_all();
        for (int c = 0; c < 3; c++) begin
            tick(c);
            chk(32'(ch_out[4]), 32'h1, "R6 disabled drives polarity");
            chk(32'(ch_out[0]), 32'(c >= 1), "R10 neighbour unaffected");
        end
        ch_en = 8'h11;
        for (int c = 3; c < 10; c++) begin
            tick(c);
            chk(32'(ch_out[4]), 32'h1, "R6 re-enable waits for on match");
        end
        tick(0);
        tick(1);
        chk(32'(ch_out[4]), 32'h0, "R6 active after on match");
    endtask

    task automatic t_run();
        ch_en = 8'h01; ch_pol = 8'h00; set_ofs(0, 1, 8);
        clear_all();
        for (int c = 0; c < 5; c++) tick(c);
        chk(32'(ch_out[0]), 32'h1, "R7 active before stop");
        run = 1'b0;
        tick(5);
        chk(32'(ch_out[0]), 32'h0, "R7 stop forces inactive");
        run = 1'b1;
        tick(6); chk(32'(ch_out[0]), 32'h0, "R7 state cleared");
        tick(7); chk(32'(ch_out[0]), 32'h0, "R7 state cleared");
        tick(9); tick(0); chk(32'(ch_out[0]), 32'h0, "R7 no spurious start");
        tick(1); chk(32'(ch_out[0]), 32'h1, "R7 restart on match");
    endtask

    task automatic t_last();
        ch_en = 8'h80; ch_pol = 8'h00; set_ofs(7, 4, 6); set_ofs(6, 4, 6);
        clear_all();
        for (int c = 0; c < 8; c++) begin
            tick(c);
            chk(32'(ch_out), 32'(((c >= 4) && (c < 6)) ? 8'h80 : 8'h00), "R10 top channel mapping");
        end
    endtask

    initial begin
        rst = 1'b1; run = 1'b0; frame_cnt = '0;
        ch_en = '0; ch_pol = '0; on_ofs = '0; off_ofs = '0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_equal();
        t_wrap();
        t_polarity();
        t_enable();
        t_run();
        t_last();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule